// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns an addressing-mode code, up to two operand bytes and the index, page and stack registers of an 8-bit processor into a 16-bit effective address. Modes that need no memory produce the address from the inputs alone. Indirect modes first fetch a two-byte pointer through a byte-wide read port with one cycle of latency, then add an index to it if the mode calls for one. Zero-page style accesses are relocated by a page register `b_reg`, which supplies the high address byte.

Requests enter on a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a pointer fetch is in flight, so the requester must hold its request until `req_ready` returns. The result has no back-pressure. `done` is a single-cycle pulse, and `ea` and `ea_valid` hold their values until the next result. All register and operand inputs are sampled only at acceptance.

Top module: `eff_addr_unit`

## Requirements
- R1: Once reset is released, `req_ready` is 1, `done` is 0 and `mem_rd` is 0.
- R2: Mode 2 (page direct) yields `{b_reg, op_lo}`.
- R3: Mode 3 (page + X) and mode 4 (page + Y) add the index to `op_lo` modulo 256 and keep `b_reg` as the high byte, so the address never leaves the page.
- R4: Mode 5 yields `{op_hi, op_lo}`. Modes 6 and 7 add unsigned X or Y to that 16-bit base, wrapping modulo 65536.
- R5: Mode 8 reads a pointer at `{op_hi, op_lo}` and mode 9 reads one at `{op_hi, op_lo} + X`. The low byte is read first and the high byte at the following 16-bit address. The result is that pointer.
- R6: Mode 10 reads the pointer low byte at `{b_reg, op_lo + X}` and the high byte at `{b_reg, (op_lo + X + 1) mod 256}`. The result is that pointer.
- R7: Mode 11 and mode 12 read a pointer at `{b_reg, op_lo}`, with the second byte at `{b_reg, (op_lo + 1) mod 256}`. They then add unsigned Y (mode 11) or Z (mode 12) modulo 65536.
- R8: Mode 13 reads a pointer at `sp_reg + op_lo`, with the second byte at the next 16-bit address and both sums taken modulo 65536. It then adds unsigned Y.
- R9: A pointer mode drives exactly two single-cycle `mem_rd` strobes, in the first and third cycles after acceptance. The read data is taken in the cycle after each strobe. `done` pulses for one cycle in the fifth cycle after acceptance.
- R10: Every mode that forms an address without memory gives `done` in the first cycle after acceptance and issues no read. This applies to modes 2 to 7 and to modes 0 (implied), 1 (immediate), 14 and 15. `ea_valid` is 0 for modes 0, 1, 14 and 15, and 1 for all other modes.
- R11: While a pointer fetch is in flight, `req_ready` is 0 and a presented request is not taken: it causes no extra `done` and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_mode | input | 4 | Addressing-mode code |
| req_op_lo | input | 8 | First operand byte |
| req_op_hi | input | 8 | Second operand byte |
| x_reg | input | 8 | X index |
| y_reg | input | 8 | Y index |
| z_reg | input | 8 | Z index |
| b_reg | input | 8 | Page register (high byte for page modes) |
| sp_reg | input | 16 | Stack pointer |
| mem_rd | output | 1 | Read strobe for a pointer byte |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| done | output | 1 | One-cycle result pulse |
| ea_valid | output | 1 | Result carries a real address |
| ea | output | 16 | Effective address |

## Verification
The hardest cases to reach from the ports are the page wrap on the second pointer byte and a request that arrives while a fetch is in flight. The wrap case is reached by putting the first pointer byte at offset 0xFF of a page, and the bench compares the strobed addresses against an independently computed address. For the busy case, a second request is held on `req_valid` during the whole fetch and withdrawn just before `req_ready` rises. The model memory returns a value that depends on the address, so a byte read from the wrong place shows up in `ea`.

// File: rtl/ea_pkg.sv
package ea_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 8;

  typedef enum logic [3:0] {
    M_IMPLIED   = 4'd0,
    M_IMMED     = 4'd1,
    M_PAGE      = 4'd2,
    M_PAGE_X    = 4'd3,
    M_PAGE_Y    = 4'd4,
    M_ABS       = 4'd5,
    M_ABS_X     = 4'd6,
    M_ABS_Y     = 4'd7,
    M_ABS_IND   = 4'd8,
    M_ABS_X_IND = 4'd9,
    M_PAGE_X_IND= 4'd10,
    M_PAGE_IND_Y= 4'd11,
    M_PAGE_IND_Z= 4'd12,
    M_STK_IND_Y = 4'd13,
    M_RSV_E     = 4'd14,
    M_RSV_F     = 4'd15
  } ea_mode_e;

  typedef enum logic [2:0] {
    F_IDLE   = 3'd0,
    F_LO_REQ = 3'd1,
    F_LO_DAT = 3'd2,
    F_HI_REQ = 3'd3,
    F_HI_DAT = 3'd4
  } fetch_st_e;
endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [3:0]        mode,
  input  logic [DATA_W-1:0] op_lo,
  input  logic [DATA_W-1:0] op_hi,
  input  logic [DATA_W-1:0] x_val,
  input  logic [DATA_W-1:0] y_val,
  input  logic [DATA_W-1:0] z_val,
  input  logic [DATA_W-1:0] b_val,
  input  logic [ADDR_W-1:0] sp_val,
  output logic              need_ptr,
  output logic              addr_ok,
  output logic [ADDR_W-1:0] direct_ea,
  output logic [ADDR_W-1:0] ptr_addr,
  output logic              ptr_in_page,
  output logic [DATA_W-1:0] post_idx
);
  import ea_pkg::*;
  localparam int EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] abs_base;
  logic [DATA_W-1:0] lo_px, lo_py;

  assign abs_base = {op_hi, op_lo};
  assign lo_px    = op_lo + x_val;
  assign lo_py    = op_lo + y_val;

  always_comb begin
    need_ptr    = 1'b0;
    addr_ok     = 1'b1;
    direct_ea   = '0;
    ptr_addr    = '0;
    ptr_in_page = 1'b0;
    post_idx    = '0;
    case (ea_mode_e'(mode))
      M_PAGE:   direct_ea = {b_val, op_lo};
      M_PAGE_X: direct_ea = {b_val, lo_px};
      M_PAGE_Y: direct_ea = {b_val, lo_py};
      M_ABS:    direct_ea = abs_base;
      M_ABS_X:  direct_ea = abs_base + {{EXT_W{1'b0}}, x_val};
      M_ABS_Y:  direct_ea = abs_base + {{EXT_W{1'b0}}, y_val};
      M_ABS_IND: begin
        need_ptr = 1'b1;
        ptr_addr = abs_base;
      end
      M_ABS_X_IND: begin
        need_ptr = 1'b1;
        ptr_addr = abs_base + {{EXT_W{1'b0}}, x_val};
      end
      M_PAGE_X_IND: begin
        need_ptr    = 1'b1;
        ptr_addr    = {b_val, lo_px};
        ptr_in_page = 1'b1;
      end
      M_PAGE_IND_Y: begin
        need_ptr    = 1'b1;
        ptr_addr    = {b_val, op_lo};
        ptr_in_page = 1'b1;
        post_idx    = y_val;
      end
      M_PAGE_IND_Z: begin
        need_ptr    = 1'b1;
        ptr_addr    = {b_val, op_lo};
        ptr_in_page = 1'b1;
        post_idx    = z_val;
      end
      M_STK_IND_Y: begin
        need_ptr = 1'b1;
        ptr_addr = sp_val + {{EXT_W{1'b0}}, op_lo};
        post_idx = y_val;
      end
      default: addr_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/ea_ptr_seq.sv
module ea_ptr_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic              ptr_in_page,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              last,
  output logic [ADDR_W-1:0] ptr_val
);
  import ea_pkg::*;

  fetch_st_e         st_q;
  logic [ADDR_W-1:0] base_q;
  logic              page_q;
  logic [DATA_W-1:0] lo_q;
  logic [ADDR_W-1:0] second_addr;
  logic [DATA_W-1:0] page_next;

  assign page_next   = base_q[DATA_W-1:0] + 1'b1;
  assign second_addr = page_q ? {base_q[ADDR_W-1:DATA_W], page_next}
                              : base_q + 1'b1;

  assign mem_rd   = (st_q == F_LO_REQ) || (st_q == F_HI_REQ);
  assign mem_addr = (st_q == F_HI_REQ) ? second_addr : base_q;
  assign busy     = (st_q != F_IDLE);
  assign last     = (st_q == F_HI_DAT);
  assign ptr_val  = {mem_rdata, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      base_q <= '0;
      page_q <= 1'b0;
      lo_q   <= '0;
    end else begin
      case (st_q)
        F_IDLE: if (start) begin
          base_q <= ptr_addr;
          page_q <= ptr_in_page;
          st_q   <= F_LO_REQ;
        end
        F_LO_REQ: st_q <= F_LO_DAT;
        F_LO_DAT: begin
          lo_q <= mem_rdata;
          st_q <= F_HI_REQ;
        end
        F_HI_REQ: st_q <= F_HI_DAT;
        default:  st_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
  parameter int ADDR_W = ea_pkg::ADDR_W,
  parameter int DATA_W = ea_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_mode,
  input  logic [DATA_W-1:0] req_op_lo,
  input  logic [DATA_W-1:0] req_op_hi,
  input  logic [DATA_W-1:0] x_reg,
  input  logic [DATA_W-1:0] y_reg,
  input  logic [DATA_W-1:0] z_reg,
  input  logic [DATA_W-1:0] b_reg,
  input  logic [ADDR_W-1:0] sp_reg,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - DATA_W;

  logic              need_ptr, addr_ok, ptr_in_page;
  logic [ADDR_W-1:0] direct_ea, ptr_addr, ptr_val;
  logic [DATA_W-1:0] post_idx, idx_q;
  logic              busy, last, accept;

  ea_mode_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .mode(req_mode), .op_lo(req_op_lo), .op_hi(req_op_hi),
    .x_val(x_reg), .y_val(y_reg), .z_val(z_reg), .b_val(b_reg),
    .sp_val(sp_reg), .need_ptr(need_ptr), .addr_ok(addr_ok),
    .direct_ea(direct_ea), .ptr_addr(ptr_addr),
    .ptr_in_page(ptr_in_page), .post_idx(post_idx)
  );

  ea_ptr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept && need_ptr),
    .ptr_addr(ptr_addr), .ptr_in_page(ptr_in_page),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .last(last), .ptr_val(ptr_val)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      ea_valid <= 1'b0;
      ea       <= '0;
      idx_q    <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (need_ptr) begin
          idx_q <= post_idx;
        end else begin
          done     <= 1'b1;
          ea_valid <= addr_ok;
          ea       <= direct_ea;
        end
      end else if (last) begin
        done     <= 1'b1;
        ea_valid <= 1'b1;
        ea       <= ptr_val + {{EXT_W{1'b0}}, idx_q};
      end
    end
  end
endmodule

// File: rtl/eff_addr_unit_chk.sv
module eff_addr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [3:0]  req_mode,
  input logic [7:0]  b_reg,
  input logic        mem_rd,
  input logic        done,
  input logic        ea_valid,
  input logic [15:0] ea
);
  AST_PAGE_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 4'd2) |=> (ea[15:8] == $past(b_reg))); // R2
  AST_PAGE_X_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 4'd3) |=> (ea[15:8] == $past(b_reg))); // R3
  AST_IMMED_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 4'd1) |=> (done && !ea_valid && !mem_rd)); // R10
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R9
  AST_NO_DONE_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !done); // R9
  AST_READY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd); // R11
endmodule

bind eff_addr_unit eff_addr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mode(req_mode), .b_reg(b_reg), .mem_rd(mem_rd), .done(done),
  .ea_valid(ea_valid), .ea(ea)
);

// File: tb/eff_addr_unit_tb_top.sv
`timescale 1ns/1ps
module eff_addr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [7:0]  req_op_lo = '0, req_op_hi = '0;
  logic [7:0]  x_reg = '0, y_reg = '0, z_reg = '0, b_reg = '0;
  logic [15:0] sp_reg = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done, ea_valid;
  logic [15:0] ea;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] got_ea;
  logic        got_v;
  int          lat, nrd;
  logic [15:0] a1, a2;

  always #2 clk = ~clk;

  eff_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_op_lo(req_op_lo), .req_op_hi(req_op_hi),
    .x_reg(x_reg), .y_reg(y_reg), .z_reg(z_reg), .b_reg(b_reg),
    .sp_reg(sp_reg), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done(done), .ea_valid(ea_valid), .ea(ea)
  );

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always_ff @(posedge clk) mem_rdata <= mem_rd ? mem_fn(mem_addr) : 8'h00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] x, input logic [7:0] y, input logic [7:0] z,
                       input logic [7:0] b, input logic [15:0] sp);
    req_mode = m; req_op_lo = lo; req_op_hi = hi;
    x_reg = x; y_reg = y; z_reg = z; b_reg = b; sp_reg = sp;
  endtask

  task automatic issue();
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    drive(4'd0, 8'hAA, 8'hAA, 8'hAA, 8'hAA, 8'hAA, 8'hAA, 16'hAAAA);
    lat = 1; nrd = 0; a1 = '0; a2 = '0; got_ea = '0; got_v = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (mem_rd) begin
        if (nrd == 0) a1 = mem_addr; else a2 = mem_addr;
        nrd++;
      end
      if (done) begin
        got_ea = ea; got_v = ea_valid;
        break;
      end
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic direct_case(input string req, input logic [3:0] m,
                             input logic [7:0] lo, input logic [7:0] hi,
                             input logic [7:0] x, input logic [7:0] y,
                             input logic [7:0] b, input logic [15:0] exp_ea,
                             input logic exp_v);
    @(negedge clk);
    drive(m, lo, hi, x, y, 8'h00, b, 16'h0000);
    issue();
    chk({req, " latency"}, lat, 1);
    chk({req, " reads"}, nrd, 0);
    chk({req, " valid"}, got_v, exp_v);
    if (exp_v) chk({req, " ea"}, got_ea, exp_ea);
  endtask

  task automatic ptr_case(input string req, input logic [3:0] m,
                          input logic [7:0] lo, input logic [7:0] hi,
                          input logic [7:0] x, input logic [7:0] y, input logic [7:0] z,
                          input logic [7:0] b, input logic [15:0] sp,
                          input logic [15:0] e1, input logic [15:0] e2,
                          input logic [7:0] idx);
    logic [15:0] exp_ea;
    exp_ea = {mem_fn(e2), mem_fn(e1)} + {8'h00, idx};
    @(negedge clk);
    drive(m, lo, hi, x, y, z, b, sp);
    issue();
    chk({req, " first ptr addr"}, a1, e1);
    chk({req, " second ptr addr"}, a2, e2);
    chk({req, " ea"}, got_ea, exp_ea);
    chk({req, " valid"}, got_v, 1'b1);
    chk("R9 strobe count", nrd, 2);
    chk("R9 latency", lat, 5);
    @(negedge clk);
    chk("R9 done pulse width", done, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 ready", req_ready, 1'b1);
    chk("R1 done", done, 1'b0);
    chk("R1 mem_rd", mem_rd, 1'b0);
  endtask

  task automatic t_page();
    direct_case("R2 page", 4'd2, 8'h34, 8'h00, 8'h00, 8'h00, 8'h12, 16'h1234, 1'b1);
    direct_case("R3 page+X wrap", 4'd3, 8'hF0, 8'h00, 8'h25, 8'h00, 8'h20, 16'h2015, 1'b1);
    direct_case("R3 page+Y wrap", 4'd4, 8'h80, 8'h00, 8'h00, 8'h90, 8'h33, 16'h3310, 1'b1);
  endtask

  task automatic t_absolute();
    direct_case("R4 abs", 4'd5, 8'hEF, 8'hBE, 8'h00, 8'h00, 8'h00, 16'hBEEF, 1'b1);
    direct_case("R4 abs+X carry", 4'd6, 8'hF0, 8'h12, 8'h20, 8'h00, 8'h00, 16'h1310, 1'b1);
    direct_case("R4 abs+Y wrap", 4'd7, 8'hF0, 8'hFF, 8'h00, 8'h20, 8'h00, 16'h0010, 1'b1);
  endtask

  task automatic t_abs_indirect();
    ptr_case("R5 abs ind", 4'd8, 8'hFF, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0,
             16'h40FF, 16'h4100, 8'h00);
    ptr_case("R5 abs X ind", 4'd9, 8'h00, 8'h30, 8'h07, 8'h00, 8'h00, 8'h00, 16'h0,
             16'h3007, 16'h3008, 8'h00);
  endtask

  task automatic t_page_x_ind();
    ptr_case("R6 page X ind wrap", 4'd10, 8'hFE, 8'h00, 8'h01, 8'h00, 8'h00, 8'h05, 16'h0,
             16'h05FF, 16'h0500, 8'h00);
  endtask

  task automatic t_page_ind_yz();
    ptr_case("R7 page ind Y", 4'd11, 8'h40, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h07, 16'h0,
             16'h0740, 16'h0741, 8'hFF);
    ptr_case("R7 page ind Z wrap", 4'd12, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h10, 8'h09, 16'h0,
             16'h09FF, 16'h0900, 8'h10);
  endtask

  task automatic t_stack_rel();
    ptr_case("R8 stack ind Y", 4'd13, 8'h20, 8'h00, 8'h00, 8'h03, 8'h00, 8'h00, 16'h01F0,
             16'h0210, 16'h0211, 8'h03);
    ptr_case("R8 stack wrap", 4'd13, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'hFFFE,
             16'hFFFF, 16'h0000, 8'h00);
  endtask

  task automatic t_no_addr();
    direct_case("R10 implied", 4'd0, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00, 16'h0, 1'b0);
    direct_case("R10 immediate", 4'd1, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00, 16'h0, 1'b0);
    direct_case("R10 reserved 14", 4'd14, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00, 16'h0, 1'b0);
    direct_case("R10 reserved 15", 4'd15, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00, 16'h0, 1'b0);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] exp_ea;
    int extra;
    exp_ea = {mem_fn(16'h5001), mem_fn(16'h5000)};
    @(negedge clk);
    drive(4'd8, 8'h00, 8'h50, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(4'd2, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00, 8'h66, 16'h0);
    extra = 0;
    for (int c = 1; c <= 4; c++) begin
      chk("R11 ready low in fetch", req_ready, 1'b0);
      if (done) extra++;
      if (c == 4) req_valid = 1'b0;
      @(negedge clk);
    end
    chk("R11 no early done", extra, 0);
    chk("R11 done after fetch", done, 1'b1);
    chk("R11 result from first request", ea, exp_ea);
    @(negedge clk);
    chk("R11 no done from ignored request", done, 1'b0);
    chk("R11 result unchanged", ea, exp_ea);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page();
    t_absolute();
    t_abs_indirect();
    t_page_x_ind();
    t_page_ind_yz();
    t_stack_rel();
    t_no_addr();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule